// File: doc/BRIEF.md
# ROM Access Arbitration Multiplexer

This block shares a single read-only memory port between two requesters: a host bus read adapter and a boot-time integrity checker. A redundantly encoded 4-bit select, driven by the checker, decides which requester owns the port. Each request carries two copies of its address. One is the storage index and the other feeds the address-tweaked keystream. Both copies pass straight through to the memory side.

The memory returns two views of each word. The bus receives the descrambled view and the checker receives the raw scrambled view. Each response goes to whichever requester issued the read, one cycle after the request. Any inconsistency latches an alert. The inconsistencies are an illegal select code, disagreeing address copies, or a response nobody asked for. From the cycle the fault is seen onward, bus responses are suppressed, so a bus read in flight never completes.

When the parameter `SCRAMBLE_EN` is 0, the select is ignored and the bus permanently owns the port.

Top module: `rom_arb_mux`

## Requirements
- R1: With `sel_i` = 4'b0110 the bus owns the port. `bus_gnt_o` is 1, and `mem_req_o` follows `bus_req_i` in the same cycle, carrying the bus indices.
- R2: With `sel_i` = 4'b1001 the checker owns the port. `bus_gnt_o` is 0 and a bus request is not forwarded. `mem_req_o` follows `chk_req_i`, carrying the checker indices.
- R3: For the owning requester, the storage index appears unchanged on `mem_idx_o` and the keystream index appears unchanged on `mem_key_idx_o`.
- R4: The bus read data is `mem_clr_rdata_i` and the checker read data is `mem_scr_rdata_i`.
- R5: A `mem_rvalid_i` arriving one cycle after a forwarded request goes only to the requester that owned the port in the request cycle, even if ownership has since changed.
- R6: Any other `sel_i` value forwards no request and sets `alert_o` on the next cycle.
- R7: A forwarded request whose two index copies differ sets `alert_o` on the next cycle.
- R8: A `mem_rvalid_i` with no request forwarded in the previous cycle sets `alert_o` on the next cycle.
- R9: Once set, `alert_o` stays 1 until reset, and reset clears it.
- R10: `bus_rvalid_o` is 0 in the cycle a fault is detected and in every cycle after it while the alert is latched.
- R11: With `SCRAMBLE_EN` = 0, `sel_i` is ignored. The bus always owns the port and an illegal select raises no alert.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 4 | Encoded owner select (0110 bus, 1001 checker) |
| bus_req_i | input | 1 | Bus read request |
| bus_idx_i | input | AW | Bus storage index |
| bus_key_idx_i | input | AW | Bus keystream index |
| bus_gnt_o | output | 1 | Bus request accepted |
| bus_rvalid_o | output | 1 | Bus read response valid |
| bus_rdata_o | output | DW | Descrambled read data to bus |
| chk_req_i | input | 1 | Checker read request |
| chk_idx_i | input | AW | Checker storage index |
| chk_key_idx_i | input | AW | Checker keystream index |
| chk_rvalid_o | output | 1 | Checker read response valid |
| chk_rdata_o | output | DW | Scrambled read data to checker |
| mem_req_o | output | 1 | Memory read request |
| mem_idx_o | output | AW | Memory storage index |
| mem_key_idx_o | output | AW | Memory keystream index |
| mem_rvalid_i | input | 1 | Memory read data valid |
| mem_scr_rdata_i | input | DW | Memory scrambled read data |
| mem_clr_rdata_i | input | DW | Memory descrambled read data |
| alert_o | output | 1 | Sticky fault alert |

## Verification
Random traffic alternates between the two legal select codes while both requesters raise requests freely. This separates correct gating from a mux that forwards the wrong requester or grants the bus while the checker owns the port. The response of each cycle is compared with the owner recorded by the bench one cycle earlier, so a directed handover right after a bus read shows whether routing uses the registered owner or the live select.

Faults are injected one at a time from a fresh reset: an illegal select, split index copies, and an unsolicited memory valid. Each must latch the alert, and an illegal select must also swallow a bus response that is already in flight. A second instance built with scrambling disabled is driven with an illegal select to confirm that the select is ignored.

// File: rtl/rom_arb_pkg.sv
package rom_arb_pkg;
  localparam int unsigned SEL_W = 4;
  localparam logic [SEL_W-1:0] SEL_BUS = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_CHK = 4'b1001;

  typedef enum logic [1:0] {
    OWN_NONE = 2'b00,
    OWN_BUS  = 2'b01,
    OWN_CHK  = 2'b10
  } owner_e;
endpackage

// File: rtl/rom_arb_sel_decode.sv
module rom_arb_sel_decode
  import rom_arb_pkg::*;
#(
  parameter bit SCRAMBLE_EN = 1'b1
) (
  input  logic [SEL_W-1:0] sel_i,
  output owner_e           owner_o,
  output logic             sel_bad_o
);
  if (SCRAMBLE_EN) begin : g_decode
    always_comb begin
      owner_o   = OWN_NONE;
      sel_bad_o = 1'b0;
      if (sel_i == SEL_BUS)      owner_o = OWN_BUS;
      else if (sel_i == SEL_CHK) owner_o = OWN_CHK;
      else                       sel_bad_o = 1'b1;
    end
  end else begin : g_passthru
    logic unused_sel;
    assign unused_sel = ^sel_i;
    assign owner_o    = OWN_BUS;
    assign sel_bad_o  = 1'b0;
  end
endmodule

// File: rtl/rom_arb_route.sv
module rom_arb_route
  import rom_arb_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  owner_e          owner_i,
  input  logic            bus_req_i,
  input  logic [AW-1:0]   bus_idx_i,
  input  logic [AW-1:0]   bus_key_idx_i,
  input  logic            chk_req_i,
  input  logic [AW-1:0]   chk_idx_i,
  input  logic [AW-1:0]   chk_key_idx_i,
  output logic            bus_gnt_o,
  output logic            mem_req_o,
  output logic [AW-1:0]   mem_idx_o,
  output logic [AW-1:0]   mem_key_idx_o,
  output logic            idx_split_o
);
  always_comb begin
    bus_gnt_o     = 1'b0;
    mem_req_o     = 1'b0;
    mem_idx_o     = '0;
    mem_key_idx_o = '0;
    unique case (owner_i)
      OWN_BUS: begin
        bus_gnt_o     = 1'b1;
        mem_req_o     = bus_req_i;
        mem_idx_o     = bus_idx_i;
        mem_key_idx_o = bus_key_idx_i;
      end
      OWN_CHK: begin
        mem_req_o     = chk_req_i;
        mem_idx_o     = chk_idx_i;
        mem_key_idx_o = chk_key_idx_i;
      end
      default: ;
    endcase
  end

  assign idx_split_o = mem_req_o && (mem_idx_o != mem_key_idx_o);
endmodule

// File: rtl/rom_arb_track.sv
module rom_arb_track
  import rom_arb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  owner_e owner_i,
  input  logic   mem_req_i,
  input  logic   mem_rvalid_i,
  input  logic   sel_bad_i,
  input  logic   idx_split_i,
  output logic   rsp_bus_o,
  output logic   rsp_chk_o,
  output logic   fault_now_o,
  output logic   alert_q_o
);
  logic pend_q, pend_d;
  logic own_bus_q, own_bus_d;
  logic alert_q, alert_d;
  logic stray_rsp;

  assign stray_rsp   = mem_rvalid_i && !pend_q;
  assign fault_now_o = sel_bad_i || idx_split_i || stray_rsp;

  always_comb begin
    pend_d    = mem_req_i;
    own_bus_d = own_bus_q;
    if (mem_req_i) own_bus_d = (owner_i == OWN_BUS);
    alert_d   = alert_q || fault_now_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      own_bus_q <= 1'b0;
      alert_q   <= 1'b0;
    end else begin
      pend_q    <= pend_d;
      own_bus_q <= own_bus_d;
      alert_q   <= alert_d;
    end
  end

  assign rsp_bus_o = mem_rvalid_i && pend_q && own_bus_q;
  assign rsp_chk_o = mem_rvalid_i && pend_q && !own_bus_q;
  assign alert_q_o = alert_q;
endmodule

// File: rtl/rom_arb_mux.sv
module rom_arb_mux
  import rom_arb_pkg::*;
#(
  parameter int unsigned AW          = 10,
  parameter int unsigned DW          = 39,
  parameter bit          SCRAMBLE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       sel_i,
  input  logic             bus_req_i,
  input  logic [AW-1:0]    bus_idx_i,
  input  logic [AW-1:0]    bus_key_idx_i,
  output logic             bus_gnt_o,
  output logic             bus_rvalid_o,
  output logic [DW-1:0]    bus_rdata_o,
  input  logic             chk_req_i,
  input  logic [AW-1:0]    chk_idx_i,
  input  logic [AW-1:0]    chk_key_idx_i,
  output logic             chk_rvalid_o,
  output logic [DW-1:0]    chk_rdata_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_idx_o,
  output logic [AW-1:0]    mem_key_idx_o,
  input  logic             mem_rvalid_i,
  input  logic [DW-1:0]    mem_scr_rdata_i,
  input  logic [DW-1:0]    mem_clr_rdata_i,
  output logic             alert_o
);
  owner_e owner;
  logic   sel_bad, idx_split, rsp_bus, fault_now, alert_q;

  rom_arb_sel_decode #(.SCRAMBLE_EN(SCRAMBLE_EN)) u_dec (
    .sel_i     (sel_i),
    .owner_o   (owner),
    .sel_bad_o (sel_bad)
  );

  rom_arb_route #(.AW(AW)) u_route (
    .owner_i       (owner),
    .bus_req_i     (bus_req_i),
    .bus_idx_i     (bus_idx_i),
    .bus_key_idx_i (bus_key_idx_i),
    .chk_req_i     (chk_req_i),
    .chk_idx_i     (chk_idx_i),
    .chk_key_idx_i (chk_key_idx_i),
    .bus_gnt_o     (bus_gnt_o),
    .mem_req_o     (mem_req_o),
    .mem_idx_o     (mem_idx_o),
    .mem_key_idx_o (mem_key_idx_o),
    .idx_split_o   (idx_split)
  );

  rom_arb_track u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .owner_i      (owner),
    .mem_req_i    (mem_req_o),
    .mem_rvalid_i (mem_rvalid_i),
    .sel_bad_i    (sel_bad),
    .idx_split_i  (idx_split),
    .rsp_bus_o    (rsp_bus),
    .rsp_chk_o    (chk_rvalid_o),
    .fault_now_o  (fault_now),
    .alert_q_o    (alert_q)
  );

  assign bus_rvalid_o = rsp_bus && !(alert_q || fault_now);
  assign bus_rdata_o  = mem_clr_rdata_i;
  assign chk_rdata_o  = mem_scr_rdata_i;
  assign alert_o      = alert_q;
endmodule

// File: rtl/rom_arb_mux_chk.sv
module rom_arb_mux_chk
  import rom_arb_pkg::*;
#(
  parameter bit SCRAMBLE_EN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] sel_i,
  input logic       bus_req_i,
  input logic       chk_req_i,
  input logic       bus_gnt_o,
  input logic       bus_rvalid_o,
  input logic       chk_rvalid_o,
  input logic       mem_req_o,
  input logic       alert_o
);
  assert_gnt_needs_bus_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (SCRAMBLE_EN && bus_gnt_o) |-> (sel_i == SEL_BUS));

  assert_req_has_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> (bus_req_i || chk_req_i));

  assert_bad_sel_alerts_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (SCRAMBLE_EN && sel_i != SEL_BUS && sel_i != SEL_CHK) |=> alert_o);

  assert_alert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alert_o |=> alert_o);

  assert_bus_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    alert_o |-> !bus_rvalid_o);

  assert_one_rsp_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rvalid_o && chk_rvalid_o));

  assert_no_alert_plain_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !SCRAMBLE_EN |-> bus_gnt_o);
endmodule

bind rom_arb_mux rom_arb_mux_chk #(.SCRAMBLE_EN(SCRAMBLE_EN)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_i        (sel_i),
  .bus_req_i    (bus_req_i),
  .chk_req_i    (chk_req_i),
  .bus_gnt_o    (bus_gnt_o),
  .bus_rvalid_o (bus_rvalid_o),
  .chk_rvalid_o (chk_rvalid_o),
  .mem_req_o    (mem_req_o),
  .alert_o      (alert_o)
);

// File: tb/rom_arb_mux_tb_top.sv
module rom_arb_mux_tb_top;
  localparam int AW = 10;
  localparam int DW = 39;
  localparam logic [3:0] S_BUS = 4'b0110;
  localparam logic [3:0] S_CHK = 4'b1001;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [3:0]    sel;
  logic          breq, creq, inject;
  logic [AW-1:0] bidx, bkey, cidx, ckey;
  logic          bus_gnt, bus_rv, chk_rv, mem_req, alert;
  logic [DW-1:0] bus_rd, chk_rd;
  logic [AW-1:0] mem_idx, mem_key;
  logic          m_rv;
  logic [AW-1:0] m_idx;

  int n_run = 0;
  int n_fail = 0;

  function automatic logic [DW-1:0] scr_of(logic [AW-1:0] i);
    return {19'h1ABCD, i, i ^ 10'h2AA};
  endfunction
  function automatic logic [DW-1:0] clr_of(logic [AW-1:0] i);
    return {19'h3C3C3, ~i, i};
  endfunction

  always @(posedge clk) begin
    m_rv  <= mem_req | inject;
    m_idx <= mem_idx;
  end

  rom_arb_mux #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel),
    .bus_req_i(breq), .bus_idx_i(bidx), .bus_key_idx_i(bkey),
    .bus_gnt_o(bus_gnt), .bus_rvalid_o(bus_rv), .bus_rdata_o(bus_rd),
    .chk_req_i(creq), .chk_idx_i(cidx), .chk_key_idx_i(ckey),
    .chk_rvalid_o(chk_rv), .chk_rdata_o(chk_rd),
    .mem_req_o(mem_req), .mem_idx_o(mem_idx), .mem_key_idx_o(mem_key),
    .mem_rvalid_i(m_rv), .mem_scr_rdata_i(scr_of(m_idx)),
    .mem_clr_rdata_i(clr_of(m_idx)), .alert_o(alert)
  );

  logic          p_gnt, p_rv, p_crv, p_req, p_alert;
  logic [DW-1:0] p_brd, p_crd;
  logic [AW-1:0] p_idx, p_key;
  rom_arb_mux #(.AW(AW), .DW(DW), .SCRAMBLE_EN(1'b0)) plain_i (
    .clk(clk), .rst_n(rst_n), .sel_i(sel),
    .bus_req_i(breq), .bus_idx_i(bidx), .bus_key_idx_i(bkey),
    .bus_gnt_o(p_gnt), .bus_rvalid_o(p_rv), .bus_rdata_o(p_brd),
    .chk_req_i(creq), .chk_idx_i(cidx), .chk_key_idx_i(ckey),
    .chk_rvalid_o(p_crv), .chk_rdata_o(p_crd),
    .mem_req_o(p_req), .mem_idx_o(p_idx), .mem_key_idx_o(p_key),
    .mem_rvalid_i(1'b0), .mem_scr_rdata_i('0), .mem_clr_rdata_i('0),
    .alert_o(p_alert)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    sel = S_BUS; breq = 0; creq = 0; inject = 0;
    bidx = '0; bkey = '0; cidx = '0; ckey = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic          e_bv, e_cv;
    logic [AW-1:0] e_idx;
    void'($urandom(32'd4711));
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 reset alert", alert, 0);
    check("R10 reset bus_rvalid", bus_rv, 0);
    rst_n = 1;

    // R1 / R3 directed bus access
    @(negedge clk);
    sel = S_BUS; breq = 1; bidx = 10'h123; bkey = 10'h123;
    #1;
    check("R1 gnt", bus_gnt, 1);
    check("R1 mem_req", mem_req, 1);
    check("R3 mem_idx", mem_idx, 10'h123);
    check("R3 mem_key_idx", mem_key, 10'h123);
    // R5 handover: next cycle checker owns, response still to bus
    @(negedge clk);
    sel = S_CHK; breq = 1; creq = 0;
    #1;
    check("R2 gnt low", bus_gnt, 0);
    check("R2 bus req blocked", mem_req, 0);
    check("R5 bus_rvalid", bus_rv, 1);
    check("R5 chk_rvalid", chk_rv, 0);
    check("R4 bus clear data", bus_rd, clr_of(10'h123));
    @(negedge clk);
    breq = 0; creq = 1; cidx = 10'h2F0; ckey = 10'h2F0;
    #1;
    check("R2 chk forwarded", mem_req, 1);
    check("R3 chk idx", mem_idx, 10'h2F0);
    check("R3 chk key", mem_key, 10'h2F0);
    @(negedge clk);
    creq = 0;
    #1;
    check("R5 chk_rvalid", chk_rv, 1);
    check("R5 no bus_rvalid", bus_rv, 0);
    check("R4 chk scrambled data", chk_rd, scr_of(10'h2F0));
    check("R9 no alert yet", alert, 0);

    // random traffic
    e_bv = 0; e_cv = 0; e_idx = '0;
    for (int k = 0; k < 400; k++) begin
      logic [AW-1:0] ib, ic;
      logic          eq;
      @(negedge clk);
      sel  = ($urandom % 2) ? S_BUS : S_CHK;
      breq = $urandom % 2; creq = $urandom % 2;
      ib = AW'($urandom); ic = AW'($urandom);
      bidx = ib; bkey = ib; cidx = ic; ckey = ic;
      #1;
      eq = (sel == S_BUS) ? breq : creq;
      check("R1 R2 random mem_req", mem_req, eq);
      check("R1 R2 random gnt", bus_gnt, sel == S_BUS);
      if (eq) check("R3 random idx", mem_idx, (sel == S_BUS) ? ib : ic);
      check("R5 random bus_rvalid", bus_rv, e_bv);
      check("R5 random chk_rvalid", chk_rv, e_cv);
      if (e_bv) check("R4 random bus data", bus_rd, clr_of(e_idx));
      if (e_cv) check("R4 random chk data", chk_rd, scr_of(e_idx));
      e_bv = eq && (sel == S_BUS);
      e_cv = eq && (sel == S_CHK);
      e_idx = (sel == S_BUS) ? ib : ic;
    end
    check("R9 random no alert", alert, 0);

    // R6 / R10: bad select swallows in-flight bus response
    do_reset();
    sel = S_BUS; breq = 1; bidx = 10'h055; bkey = 10'h055;
    @(negedge clk);
    breq = 0; sel = 4'b1111;
    #1;
    check("R6 bad sel no req", mem_req, 0);
    check("R10 same-cycle suppress", bus_rv, 0);
    @(negedge clk);
    sel = S_BUS; breq = 1;
    #1;
    check("R6 alert after bad sel", alert, 1);
    @(negedge clk);
    breq = 0;
    #1;
    check("R10 bus silent after alert", bus_rv, 0);
    check("R9 alert held", alert, 1);
    do_reset();
    #1;
    check("R9 reset clears alert", alert, 0);

    // R7 split indices
    @(negedge clk);
    sel = S_BUS; breq = 1; bidx = 10'h010; bkey = 10'h011;
    @(negedge clk);
    idle();
    #1;
    check("R7 alert on split idx", alert, 1);

    // R8 stray response
    do_reset();
    inject = 1;
    @(negedge clk);
    inject = 0;
    @(negedge clk);
    #1;
    check("R8 alert on stray rvalid", alert, 1);

    // R11 plain variant ignores select
    do_reset();
    sel = 4'b0000; breq = 1; bidx = 10'h0AA; bkey = 10'h0AA;
    #1;
    check("R11 plain gnt", p_gnt, 1);
    check("R11 plain req", p_req, 1);
    @(negedge clk);
    #1;
    check("R11 plain no alert", p_alert, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule